// File: doc/BRIEF.md
# Scaled Integer Add and Compare Unit

This block is the integer add/subtract/compare slice of a 64-bit execution pipeline. Each cycle it may accept one operation, picked by a 7-bit function code. Operand A is always a 64-bit register value. Operand B is either a 64-bit register value or an 8-bit literal, and a select input chooses between them.

The arithmetic operations work at two widths. Longword (32-bit) results are sign-extended to 64 bits, and quadword results use all 64 bits. Before the add or subtract, A can be shifted left by 2 or 3 places. Four of the codes trap on signed overflow: the wrapped result is still delivered, and a trap flag is raised alongside it.

The compare operations produce 0 or 1. A byte-parallel unsigned compare produces an 8-bit mask. Every result is registered, so the latency is one cycle. Function codes that the unit does not implement raise an illegal flag. Instruction decode, the register file and trap delivery are handled by the surrounding pipeline.

Top module: `iadd_unit`

## Requirements
- R1: While rst_ni is low, and after it rises until the first accepted operation, valid_o, result_o, ovf_trap_o and illegal_o are all zero.
- R2: An operation presented with valid_i high at a rising edge appears on the outputs after that edge, with valid_o high. After an edge where valid_i is low, valid_o, ovf_trap_o and illegal_o are low and result_o keeps its previous value.
- R3: The quad add codes are 0x20, 0x22 and 0x32, and the quad subtract codes are 0x29, 0x2b and 0x3b. Each computes (A << s) + B or (A << s) - B modulo 2^64, where s is 0, 2 or 3 in that order.
- R4: The longword codes are add 0x00, 0x02 and 0x12, and subtract 0x09, 0x0b and 0x1b, with s equal to 0, 2 and 3 in that order. Each computes the same expression on the low 32 bits, and result_o is that 32-bit value sign-extended to 64 bits. The upper 32 bits of A and B have no effect.
- R5: The trapping adds are 0x40 (longword) and 0x60 (quad). An add overflows when A and B have the same sign bit and the sign bit of the sum differs from A's sign bit. The sign bit is bit 31 for longword and bit 63 for quad. On overflow, ovf_trap_o is high in the same cycle that the wrapped sum appears on result_o.
- R6: The trapping subtracts are 0x49 (longword) and 0x69 (quad). A subtract overflows only when A and B have different sign bits and the sign bit of the difference differs from A's sign bit.
- R7: Codes other than 0x40, 0x60, 0x49 and 0x69 never raise ovf_trap_o, even when their result wraps.
- R8: The compare codes are 0x2d (A == B), 0x6d (signed A <= B), 0x4d (signed A < B), 0x3d (unsigned A <= B) and 0x1d (unsigned A < B). Each gives result_o = 1 when the comparison is true and 0 otherwise.
- R9: Code 0x0f sets result bit i (i = 0..7) when byte i of A (bits 8i+7..8i) is unsigned greater than or equal to byte i of B. Bits 63..8 are zero.
- R10: When lit_sel_i is high, B is lit_i zero-extended to 64 bits and b_reg_i is ignored.
- R11: Any other function code gives illegal_o = 1, result_o = 0 and ovf_trap_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| func_i | input | 7 | Function code |
| a_i | input | 64 | Operand A |
| b_reg_i | input | 64 | Register form of operand B |
| lit_sel_i | input | 1 | Selects the literal as B |
| lit_i | input | 8 | Literal form of operand B |
| valid_o | output | 1 | Registered result valid |
| result_o | output | 64 | Registered result |
| ovf_trap_o | output | 1 | Trapping operation overflowed |
| illegal_o | output | 1 | Function code not implemented |

## Verification
The two functions that can coincide are the write of a wrapped result and the raising of the overflow trap. Both belong to the same trapping operation and must appear in the same output cycle. The bench provokes this at both widths and for both directions: largest positive plus one, two most-negative values added together, and opposite-signed subtractions that cross the sign boundary. In each case it checks result_o and ovf_trap_o together, at one sample point. The same wrapping inputs are also sent with the non-trapping codes, to confirm that the flag is not raised for them.

// File: rtl/iadd_pkg.sv
package iadd_pkg;
  localparam int FUNC_W = 7;

  typedef enum logic [1:0] {U_NONE, U_ARITH, U_CMP, U_BYTE} unit_e;
  typedef enum logic [2:0] {C_EQ, C_SLE, C_SLT, C_ULE, C_ULT} cmp_e;

  typedef struct packed {
    unit_e      unit;
    logic       sub;
    logic       lw;
    logic [1:0] shamt;
    logic       trap;
    cmp_e       cmp;
  } ctl_t;
endpackage

// File: rtl/iadd_decode.sv
module iadd_decode
  import iadd_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output ctl_t              ctl_o
);
  always_comb begin
    ctl_o = '{unit: U_NONE, sub: 1'b0, lw: 1'b0, shamt: 2'd0, trap: 1'b0, cmp: C_EQ};
    case (func_i)
      7'h00: begin ctl_o.unit = U_ARITH; ctl_o.lw = 1'b1; end
      7'h40: begin ctl_o.unit = U_ARITH; ctl_o.lw = 1'b1; ctl_o.trap = 1'b1; end
      7'h02: begin ctl_o.unit = U_ARITH; ctl_o.lw = 1'b1; ctl_o.shamt = 2'd2; end
      7'h12: begin ctl_o.unit = U_ARITH; ctl_o.lw = 1'b1; ctl_o.shamt = 2'd3; end
      7'h20: begin ctl_o.unit = U_ARITH; end
      7'h60: begin ctl_o.unit = U_ARITH; ctl_o.trap = 1'b1; end
      7'h22: begin ctl_o.unit = U_ARITH; ctl_o.shamt = 2'd2; end
      7'h32: begin ctl_o.unit = U_ARITH; ctl_o.shamt = 2'd3; end
      7'h09: begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.lw = 1'b1; end
      7'h49: begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.lw = 1'b1; ctl_o.trap = 1'b1; end
      7'h0b: begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.lw = 1'b1; ctl_o.shamt = 2'd2; end
      7'h1b: begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.lw = 1'b1; ctl_o.shamt = 2'd3; end
      7'h29: begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; end
      7'h69: begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.trap = 1'b1; end
      7'h2b: begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.shamt = 2'd2; end
      7'h3b: begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.shamt = 2'd3; end
      7'h2d: begin ctl_o.unit = U_CMP; ctl_o.cmp = C_EQ;  end
      7'h6d: begin ctl_o.unit = U_CMP; ctl_o.cmp = C_SLE; end
      7'h4d: begin ctl_o.unit = U_CMP; ctl_o.cmp = C_SLT; end
      7'h3d: begin ctl_o.unit = U_CMP; ctl_o.cmp = C_ULE; end
      7'h1d: begin ctl_o.unit = U_CMP; ctl_o.cmp = C_ULT; end
      7'h0f: begin ctl_o.unit = U_BYTE; end
      default: ;
    endcase
  end

  // Trapping forms are never scaled (R5, R6)
  always_comb begin
    assert_trap_unscaled_R5: assert (!(ctl_o.trap && ctl_o.shamt != 2'd0));
  end
endmodule

// File: rtl/iadd_addsub.sv
module iadd_addsub #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              lw_i,
  input  logic [1:0]        shamt_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] a_sc, raw;
  logic              sa, sb, sr;

  always_comb begin
    a_sc = a_i << shamt_i;
    raw  = sub_i ? (a_sc - b_i) : (a_sc + b_i);
    if (lw_i) begin
      res_o = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
      sa = a_sc[HALF_W-1];
      sb = b_i[HALF_W-1];
      sr = raw[HALF_W-1];
    end else begin
      res_o = raw;
      sa = a_sc[DATA_W-1];
      sb = b_i[DATA_W-1];
      sr = raw[DATA_W-1];
    end
    // subtract overflows only for unlike signs, add only for like signs
    ovf_o = (sub_i ? (sa != sb) : (sa == sb)) && (sr != sa);
  end
endmodule

// File: rtl/iadd_cmp.sv
module iadd_cmp
  import iadd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  cmp_e              cmp_i,
  output logic [DATA_W-1:0] cmp_res_o,
  output logic [DATA_W-1:0] byte_res_o
);
  localparam int NBYTES = DATA_W / 8;

  logic eq, slt, ult, bit_r;
  logic [NBYTES-1:0] ge_mask;

  always_comb begin
    eq  = (a_i == b_i);
    slt = ($signed(a_i) < $signed(b_i));
    ult = (a_i < b_i);
    unique case (cmp_i)
      C_EQ:    bit_r = eq;
      C_SLE:   bit_r = slt | eq;
      C_SLT:   bit_r = slt;
      C_ULE:   bit_r = ult | eq;
      C_ULT:   bit_r = ult;
      default: bit_r = 1'b0;
    endcase
    cmp_res_o = {{(DATA_W-1){1'b0}}, bit_r};
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign ge_mask[i] = (a_i[8*i +: 8] >= b_i[8*i +: 8]);
  end

  assign byte_res_o = {{(DATA_W-NBYTES){1'b0}}, ge_mask};
endmodule

// File: rtl/iadd_unit.sv
module iadd_unit
  import iadd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_reg_i,
  input  logic              lit_sel_i,
  input  logic [LIT_W-1:0]  lit_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_trap_o,
  output logic              illegal_o
);
  localparam int NBYTES = DATA_W / 8;

  ctl_t              ctl;
  logic [DATA_W-1:0] b_op, as_res, cmp_res, byte_res, res_d;
  logic              as_ovf, ovf_d, ill_d;

  assign b_op = lit_sel_i ? {{(DATA_W-LIT_W){1'b0}}, lit_i} : b_reg_i;

  iadd_decode u_dec (.func_i(func_i), .ctl_o(ctl));

  iadd_addsub #(.DATA_W(DATA_W)) u_as (
    .a_i(a_i), .b_i(b_op), .sub_i(ctl.sub), .lw_i(ctl.lw),
    .shamt_i(ctl.shamt), .res_o(as_res), .ovf_o(as_ovf)
  );

  iadd_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a_i(a_i), .b_i(b_op), .cmp_i(ctl.cmp),
    .cmp_res_o(cmp_res), .byte_res_o(byte_res)
  );

  always_comb begin
    ovf_d = 1'b0;
    ill_d = 1'b0;
    unique case (ctl.unit)
      U_ARITH: begin res_d = as_res; ovf_d = ctl.trap & as_ovf; end
      U_CMP:   res_d = cmp_res;
      U_BYTE:  res_d = byte_res;
      default: begin res_d = '0; ill_d = 1'b1; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      ovf_trap_o <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      ovf_trap_o <= valid_i & ovf_d;
      illegal_o  <= valid_i & ill_d;
      if (valid_i) result_o <= res_d;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !ovf_trap_o && !illegal_o && $stable(result_o)));
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ctl.trap) |=> !ovf_trap_o);
  assert_illegal_clean_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!ovf_trap_o && result_o == '0 && valid_o));
  assert_cmp_boolean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.unit == U_CMP) |=> (result_o[DATA_W-1:1] == '0));
  assert_byte_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.unit == U_BYTE) |=> (result_o[DATA_W-1:NBYTES] == '0));
endmodule

// File: tb/iadd_unit_tb.sv
module iadd_unit_tb;
  typedef struct packed {
    logic [3:0]  req;
    logic [6:0]  func;
    logic        lsel;
    logic [7:0]  lit;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic        ovf;
    logic        ill;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VEC [NV] = '{
    '{4'd3, 7'h20, 1'b0, 8'h00, 64'h0123_4567_89ab_cdef, 64'h1111_1111_1111_1111, 64'h1234_5678_9abc_df00, 1'b0, 1'b0}, // R3
    '{4'd3, 7'h22, 1'b0, 8'h00, 64'd1, 64'd5, 64'd9, 1'b0, 1'b0},                                                   // R3
    '{4'd3, 7'h32, 1'b0, 8'h00, 64'd3, 64'd1, 64'h19, 1'b0, 1'b0},                                                  // R3
    '{4'd3, 7'h2b, 1'b0, 8'h00, 64'd2, 64'd10, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0},                                // R3
    '{4'd3, 7'h3b, 1'b0, 8'h00, 64'd1, 64'd8, 64'd0, 1'b0, 1'b0},                                                   // R3
    '{4'd3, 7'h29, 1'b0, 8'h00, 64'd5, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0},                                 // R3
    '{4'd7, 7'h00, 1'b0, 8'h00, 64'h7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0},                         // R7 R4
    '{4'd5, 7'h40, 1'b0, 8'h00, 64'h7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0},                         // R5
    '{4'd4, 7'h40, 1'b0, 8'h00, 64'hFFFF_FFFF_0000_0005, 64'd3, 64'd8, 1'b0, 1'b0},                                 // R4
    '{4'd4, 7'h02, 1'b0, 8'h00, 64'h2000_0000, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0},                         // R4
    '{4'd4, 7'h12, 1'b0, 8'h00, 64'd1, 64'hFFFF_FFFF, 64'd7, 1'b0, 1'b0},                                           // R4
    '{4'd4, 7'h09, 1'b0, 8'h00, 64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},                                 // R4
    '{4'd6, 7'h49, 1'b0, 8'h00, 64'h8000_0000, 64'd1, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0},                         // R6
    '{4'd6, 7'h49, 1'b0, 8'h00, 64'h8000_0000, 64'h8000_0000, 64'd0, 1'b0, 1'b0},                                   // R6
    '{4'd4, 7'h0b, 1'b0, 8'h00, 64'd1, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},                                 // R4
    '{4'd4, 7'h1b, 1'b0, 8'h00, 64'h1000_0000, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0},                         // R4
    '{4'd5, 7'h60, 1'b0, 8'h00, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 1'b1, 1'b0},               // R5
    '{4'd5, 7'h60, 1'b0, 8'h00, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 1'b1, 1'b0},               // R5
    '{4'd6, 7'h69, 1'b0, 8'h00, 64'h8000_0000_0000_0000, 64'd1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},               // R6
    '{4'd6, 7'h69, 1'b0, 8'h00, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, 1'b0}, // R6
    '{4'd6, 7'h69, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 1'b0},               // R6
    '{4'd7, 7'h20, 1'b0, 8'h00, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 1'b0, 1'b0},               // R7
    '{4'd8, 7'h2d, 1'b0, 8'h00, 64'h55, 64'h55, 64'd1, 1'b0, 1'b0},                                                 // R8
    '{4'd8, 7'h2d, 1'b0, 8'h00, 64'd5, 64'd6, 64'd0, 1'b0, 1'b0},                                                   // R8
    '{4'd8, 7'h6d, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd1, 1'b0, 1'b0},                                 // R8
    '{4'd8, 7'h6d, 1'b0, 8'h00, 64'd3, 64'd3, 64'd1, 1'b0, 1'b0},                                                   // R8
    '{4'd8, 7'h4d, 1'b0, 8'h00, 64'd3, 64'd3, 64'd0, 1'b0, 1'b0},                                                   // R8
    '{4'd8, 7'h4d, 1'b0, 8'h00, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b0},               // R8
    '{4'd8, 7'h3d, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 1'b0, 1'b0},                                 // R8
    '{4'd8, 7'h1d, 1'b0, 8'h00, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b0},                                 // R8
    '{4'd8, 7'h1d, 1'b0, 8'h00, 64'd4, 64'd4, 64'd0, 1'b0, 1'b0},                                                   // R8
    '{4'd9, 7'h0f, 1'b0, 8'h00, 64'h00FF_7F80_0102_0304, 64'h0100_8080_0101_0504, 64'h5D, 1'b0, 1'b0},              // R9
    '{4'd9, 7'h0f, 1'b0, 8'h00, 64'd0, 64'd0, 64'hFF, 1'b0, 1'b0},                                                  // R9
    '{4'd10, 7'h20, 1'b1, 8'hFF, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h100, 1'b0, 1'b0},                              // R10
    '{4'd10, 7'h4d, 1'b1, 8'hFF, 64'h80, 64'd0, 64'd1, 1'b0, 1'b0},                                                 // R10
    '{4'd10, 7'h0f, 1'b1, 8'h00, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF, 1'b0, 1'b0},                               // R10
    '{4'd11, 7'h01, 1'b0, 8'h00, 64'd5, 64'd5, 64'd0, 1'b0, 1'b1},                                                  // R11
    '{4'd11, 7'h7f, 1'b0, 8'h00, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0, 1'b1},                                // R11
    '{4'd11, 7'h61, 1'b0, 8'h00, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 1'b0, 1'b1}               // R11
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [6:0]  func_i = '0;
  logic [63:0] a_i = '0, b_reg_i = '0;
  logic        lit_sel_i = 1'b0;
  logic [7:0]  lit_i = '0;
  logic        valid_o, ovf_trap_o, illegal_o;
  logic [63:0] result_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2ns clk_i = ~clk_i;

  iadd_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .func_i(func_i),
    .a_i(a_i), .b_reg_i(b_reg_i), .lit_sel_i(lit_sel_i), .lit_i(lit_i),
    .valid_o(valid_o), .result_o(result_o), .ovf_trap_o(ovf_trap_o), .illegal_o(illegal_o)
  );

  task automatic check(input string req, input logic v, input logic [63:0] r,
                       input logic o, input logic il);
    checks++;
    if (valid_o !== v || result_o !== r || ovf_trap_o !== o || illegal_o !== il) begin
      errors++;
      $display("FAIL %s: got v=%0b res=%h ovf=%0b ill=%0b, expected v=%0b res=%h ovf=%0b ill=%0b",
               req, valid_o, result_o, ovf_trap_o, illegal_o, v, r, o, il);
    end
  endtask

  task automatic drive(input logic v, input logic [6:0] f, input logic [63:0] a,
                       input logic [63:0] b, input logic ls, input logic [7:0] l);
    valid_i = v; func_i = f; a_i = a; b_reg_i = b; lit_sel_i = ls; lit_i = l;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 1'b0, 64'd0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 1'b0, 64'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].func, VEC[i].a, VEC[i].b, VEC[i].lsel, VEC[i].lit);
      @(negedge clk_i);
      check($sformatf("R%0d vec %0d", VEC[i].req, i), 1'b1, VEC[i].res, VEC[i].ovf, VEC[i].ill);
    end

    // R2: idle cycle holds result, clears flags even with trap-worthy inputs
    drive(1'b1, 7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 8'h00);
    @(negedge clk_i);
    check("R5 trap before idle", 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0);
    drive(1'b0, 7'h60, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 8'h00);
    @(negedge clk_i);
    check("R2 idle holds", 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
    drive(1'b0, 7'h7f, 64'd0, 64'd0, 1'b0, 8'h00);
    @(negedge clk_i);
    check("R2 idle illegal code", 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0);

    // R2: back-to-back results, one cycle latency
    drive(1'b1, 7'h20, 64'd10, 64'd20, 1'b0, 8'h00);
    @(negedge clk_i);
    check("R2 first of pair", 1'b1, 64'd30, 1'b0, 1'b0);
    drive(1'b1, 7'h29, 64'd10, 64'd20, 1'b0, 8'h00);
    @(negedge clk_i);
    check("R2 second of pair", 1'b1, 64'hFFFF_FFFF_FFFF_FFF6, 1'b0, 1'b0);

    // R10: b_reg ignored under literal select
    drive(1'b1, 7'h2d, 64'h42, 64'h1234, 1'b1, 8'h42);
    @(negedge clk_i);
    check("R10 literal eq", 1'b1, 64'd1, 1'b0, 1'b0);

    // R4: upper operand bits ignored in longword subtract with trap
    drive(1'b1, 7'h49, 64'hDEAD_BEEF_0000_0010, 64'h1234_5678_0000_0004, 1'b0, 8'h00);
    @(negedge clk_i);
    check("R4 upper ignored", 1'b1, 64'd12, 1'b0, 1'b0);

    // R1: reset in mid-run
    drive(1'b1, 7'h20, 64'd1, 64'd1, 1'b0, 8'h00);
    #1ns rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid-run reset", 1'b0, 64'd0, 1'b0, 1'b0);
    drive(1'b0, 7'h00, 64'd0, 64'd0, 1'b0, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 quiet after reset", 1'b0, 64'd0, 1'b0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule